// File: doc/BRIEF.md
# Multi-Device Synthesizer Alignment Sequencer

This controller brings a group of direct-synthesis devices into lockstep. After a single `start` pulse it drives a common reset to every device. It then issues an ordered series of register writes over a shared write port, addressed by device index. Between groups of writes it pulses a shared update strobe, so that the devices act on the new register values together. One device, selected by a parameter, is the timing master. Some steps write to the master only; the other steps write to every device in ascending index order.

The bring-up runs in this order:

1. A converter calibration: set, update, clear, update.
2. Enable the master's sync output.
3. Arm the calibrate-with-sync mode on every device.
4. Load the sync-output delay into the master.
5. A second calibration pass.
6. Load profile mode and the requested tuning word into every device, with no update in between.

Every update strobe before the last one may be asynchronous to the devices. The last one may not. It is launched only after a falling edge of the sampled device sync clock, which leaves a full low half-period of setup before the next rising edge. `done` follows one cycle later.

Each write is presented with `wrValid` and held until `busReady` accepts it. A serializer or bus bridge downstream converts these writes to the device wire protocol.

Top module: `sync_seq_top`

## Requirements
- R1: After reset all outputs are low. A `start` seen while idle or done raises `masterReset` for exactly RST_CYC cycles. No write and no update is issued while `masterReset` is high.
- R2: While `wrValid` is high and `busReady` is low, `wrValid`, `wrDev`, `wrAddr` and `wrData` hold their values. A write counts as done in the cycle in which `wrValid` and `busReady` are both high.
- R3: A step that targets every device issues one write per device, to indices 0 to N_DEV-1 in ascending order.
- R4: Calibration pass 1 writes address 0x03 with data bit 24 set to every device, then updates. It then writes 0x03 with data 0 to every device, then updates.
- R5: Next, address 0x01 is written with only bit 9 set (sync-output enable), to the master device MASTER_IDX only, followed by an update.
- R6: Next, address 0x1B is written with only bit 24 set (calibrate-with-sync) to every device, followed by an update. Then the master alone gets 0x1B with bit 24 set and `syncDelay` (captured at start) in bits [DLY_W-1:0], followed by an update.
- R7: The calibration pass of R4 then repeats in full on every device, master included.
- R8: Finally, address 0x01 is written with only bit 23 set (profile mode) to every device. Then address 0x0B is written with `tuneWord` (captured at start) to every device. No update is issued in between.
- R9: After the last write of R8, the final update waits for a falling edge of `syncClk`, seen through two sampling flops. It is a single-cycle pulse, two clock cycles after the cycle in which `syncClk` went low.
- R10: `done` rises the cycle after the final update and stays high until the next `start`. A `start` during a running sequence is ignored.
- R11: Every update before the final one is a single-cycle pulse. It comes in the cycle right after the last accepted write of its step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the bring-up sequence |
| syncDelay | input | DLY_W | Sync-output delay value for the master |
| tuneWord | input | DATA_W | Tuning word for profile 0 |
| busReady | input | 1 | Write port accepts the current write |
| syncClk | input | 1 | Copy of the devices' sync clock |
| wrValid | output | 1 | A write is presented |
| wrDev | output | DEV_W | Target device index |
| wrAddr | output | 8 | Register address |
| wrData | output | DATA_W | Register data |
| ioUpdate | output | 1 | Shared update strobe to all devices |
| masterReset | output | 1 | Shared reset to all devices |
| done | output | 1 | Sequence complete |

## Verification
The bench compares the full stream of writes and updates against the ordered list derived from the requirements. It does this under three back-pressure patterns, with a non-zero master index and a delay at both its smallest and largest values. A controller that wrote the sync-enable or delay register to every device, skipped a calibration clear, or updated between the profile and tuning writes would produce a stream that no longer matches. During stalls it checks that the presented write holds its values; a design that advanced on `wrValid` alone would drop or repeat writes. It also checks the exact spacing between the falling edge of `syncClk` and the final strobe, and between that strobe and `done`. A second `start` is injected mid-run; a design that restarted on it would repeat the reset and the calibration writes.

// File: rtl/sync_seq_pkg.sv
package sync_seq_pkg;

  localparam int NUM_STEPS   = 9;
  localparam int STEP_W      = 4;

  localparam logic [7:0] ADDR_CAL  = 8'h03;
  localparam logic [7:0] ADDR_CTL  = 8'h01;
  localparam logic [7:0] ADDR_SYNC = 8'h1B;
  localparam logic [7:0] ADDR_FTW0 = 8'h0B;

  localparam int CAL_BIT     = 24;
  localparam int SYNCOUT_BIT = 9;
  localparam int PROFEN_BIT  = 23;
  localparam int CALSYNC_BIT = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_WRITE,
    ST_UPD,
    ST_SYNCWAIT,
    ST_FINAL,
    ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clrStep;
    logic nextStep;
    logic clrDev;
    logic nextDev;
  } dpCtrl_t;

endpackage

// File: rtl/sync_seq_dp.sv
module sync_seq_dp
  import sync_seq_pkg::*;
#(
  parameter int N_DEV      = 3,
  parameter int MASTER_IDX = 1,
  parameter int DLY_W      = 5,
  parameter int DATA_W     = 32,
  localparam int DEV_W     = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [DLY_W-1:0]  syncDelay,
  input  logic [DATA_W-1:0] tuneWord,
  output logic [DEV_W-1:0]  wrDev,
  output logic [7:0]        wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              lastDev,
  output logic              lastStep,
  output logic              stepUpd
);

  localparam logic [DATA_W-1:0] ONE          = 1;
  localparam logic [DATA_W-1:0] CAL_MASK     = ONE << CAL_BIT;
  localparam logic [DATA_W-1:0] SYNCOUT_MASK = ONE << SYNCOUT_BIT;
  localparam logic [DATA_W-1:0] PROFEN_MASK  = ONE << PROFEN_BIT;
  localparam logic [DATA_W-1:0] CALSYNC_MASK = ONE << CALSYNC_BIT;
  localparam logic [DEV_W-1:0]  MASTER_SEL   = DEV_W'(MASTER_IDX);
  localparam logic [DEV_W-1:0]  LAST_DEV     = DEV_W'(N_DEV - 1);
  localparam logic [STEP_W-1:0] LAST_STEP    = STEP_W'(NUM_STEPS - 1);

  logic [STEP_W-1:0] stepIdx;
  logic [DEV_W-1:0]  devIdx;
  logic [DLY_W-1:0]  dlyQ;
  logic [DATA_W-1:0] tuneQ;
  logic              masterOnly;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepIdx <= '0;
      devIdx  <= '0;
      dlyQ    <= '0;
      tuneQ   <= '0;
    end else begin
      if (ctl.capture) begin
        dlyQ  <= syncDelay;
        tuneQ <= tuneWord;
      end
      if (ctl.clrStep)       stepIdx <= '0;
      else if (ctl.nextStep) stepIdx <= stepIdx + 1'b1;
      if (ctl.clrDev)        devIdx <= '0;
      else if (ctl.nextDev)  devIdx <= devIdx + 1'b1;
    end
  end

  // step table: address, data, target set, trailing update
  always_comb begin
    wrAddr     = '0;
    wrData     = '0;
    masterOnly = 1'b0;
    stepUpd    = 1'b0;
    case (stepIdx)
      4'd0, 4'd5: begin wrAddr = ADDR_CAL;  wrData = CAL_MASK; stepUpd = 1'b1; end
      4'd1, 4'd6: begin wrAddr = ADDR_CAL;  wrData = '0;       stepUpd = 1'b1; end
      4'd2: begin
        wrAddr = ADDR_CTL; wrData = SYNCOUT_MASK; masterOnly = 1'b1; stepUpd = 1'b1;
      end
      4'd3: begin wrAddr = ADDR_SYNC; wrData = CALSYNC_MASK; stepUpd = 1'b1; end
      4'd4: begin
        wrAddr     = ADDR_SYNC;
        wrData     = CALSYNC_MASK | {{(DATA_W-DLY_W){1'b0}}, dlyQ};
        masterOnly = 1'b1;
        stepUpd    = 1'b1;
      end
      4'd7: begin wrAddr = ADDR_CTL;  wrData = PROFEN_MASK; end
      4'd8: begin wrAddr = ADDR_FTW0; wrData = tuneQ;       end
      default: ;
    endcase
  end

  assign wrDev    = masterOnly ? MASTER_SEL : devIdx;
  assign lastDev  = masterOnly || (devIdx == LAST_DEV);
  assign lastStep = (stepIdx == LAST_STEP);

  // R3: the device index never leaves the configured range
  p_dev_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.nextDev |-> (devIdx != LAST_DEV));

endmodule

// File: rtl/sync_seq_ctl.sv
module sync_seq_ctl
  import sync_seq_pkg::*;
#(
  parameter int RST_CYC = 4,
  localparam int RC_W   = $clog2(RST_CYC + 1)
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    busReady,
  input  logic    syncClk,
  input  logic    lastDev,
  input  logic    lastStep,
  input  logic    stepUpd,
  output dpCtrl_t ctl,
  output logic    wrValid,
  output logic    ioUpdate,
  output logic    masterReset,
  output logic    done
);

  localparam logic [RC_W-1:0] RST_LAST = RC_W'(RST_CYC - 1);

  seqState_t       state, stateNxt;
  logic [RC_W-1:0] rstCnt;
  logic            syncS1, syncS2, syncFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncS1 <= 1'b0;
      syncS2 <= 1'b0;
    end else begin
      syncS1 <= syncClk;
      syncS2 <= syncS1;
    end
  end
  assign syncFall = syncS2 && !syncS1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rstCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state != ST_RST)         rstCnt <= '0;
      else if (rstCnt != RST_LAST) rstCnt <= rstCnt + 1'b1;
    end
  end

  always_comb begin
    stateNxt    = state;
    ctl         = '0;
    wrValid     = 1'b0;
    ioUpdate    = 1'b0;
    masterReset = 1'b0;
    done        = 1'b0;
    case (state)
      ST_IDLE, ST_DONE: begin
        done = (state == ST_DONE);
        if (start) begin
          ctl.capture = 1'b1;
          ctl.clrStep = 1'b1;
          ctl.clrDev  = 1'b1;
          stateNxt    = ST_RST;
        end
      end
      ST_RST: begin
        masterReset = 1'b1;
        if (rstCnt == RST_LAST) stateNxt = ST_WRITE;
      end
      ST_WRITE: begin
        wrValid = 1'b1;
        if (busReady) begin
          if (!lastDev) begin
            ctl.nextDev = 1'b1;
          end else if (stepUpd) begin
            stateNxt = ST_UPD;
          end else if (lastStep) begin
            stateNxt = ST_SYNCWAIT;
          end else begin
            ctl.nextStep = 1'b1;
            ctl.clrDev   = 1'b1;
          end
        end
      end
      ST_UPD: begin
        ioUpdate     = 1'b1;
        ctl.nextStep = 1'b1;
        ctl.clrDev   = 1'b1;
        stateNxt     = ST_WRITE;
      end
      ST_SYNCWAIT: if (syncFall) stateNxt = ST_FINAL;
      ST_FINAL: begin
        ioUpdate = 1'b1;
        stateNxt = ST_DONE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  p_rst_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    masterReset |-> (!wrValid && !ioUpdate));

  p_upd_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    ioUpdate |=> !ioUpdate);

  p_upd_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    ioUpdate |-> ($past(wrValid && busReady) || $past(syncFall)));

  p_done_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(ioUpdate));

endmodule

// File: rtl/sync_seq_top.sv
module sync_seq_top
  import sync_seq_pkg::*;
#(
  parameter int N_DEV      = 3,
  parameter int MASTER_IDX = 1,
  parameter int DLY_W      = 5,
  parameter int DATA_W     = 32,
  parameter int RST_CYC    = 4,
  localparam int DEV_W     = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DLY_W-1:0]  syncDelay,
  input  logic [DATA_W-1:0] tuneWord,
  input  logic              busReady,
  input  logic              syncClk,
  output logic              wrValid,
  output logic [DEV_W-1:0]  wrDev,
  output logic [7:0]        wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              ioUpdate,
  output logic              masterReset,
  output logic              done
);

  dpCtrl_t ctl;
  logic    lastDev, lastStep, stepUpd;

  sync_seq_ctl #(.RST_CYC(RST_CYC)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .busReady(busReady),
    .syncClk(syncClk), .lastDev(lastDev), .lastStep(lastStep),
    .stepUpd(stepUpd), .ctl(ctl), .wrValid(wrValid), .ioUpdate(ioUpdate),
    .masterReset(masterReset), .done(done)
  );

  sync_seq_dp #(
    .N_DEV(N_DEV), .MASTER_IDX(MASTER_IDX), .DLY_W(DLY_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .syncDelay(syncDelay),
    .tuneWord(tuneWord), .wrDev(wrDev), .wrAddr(wrAddr), .wrData(wrData),
    .lastDev(lastDev), .lastStep(lastStep), .stepUpd(stepUpd)
  );

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !busReady) |=> (wrValid && $stable(wrDev) && $stable(wrAddr)
                                && $stable(wrData)));

  p_no_mixed_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && ioUpdate));

endmodule

// File: tb/tb_sync_seq_top.sv
`timescale 1ns/1ps
module tb_sync_seq_top;
  localparam int N_DEV = 3, MASTER = 1, DLY_W = 5, DATA_W = 32, RST_CYC = 4;
  localparam int DEV_W = 2, SYNC_HALF = 8, MAXEV = 128;

  typedef struct packed {
    logic [DLY_W-1:0]  dly;
    logic [DATA_W-1:0] tune;
    logic [1:0]        stall;
    logic              poke;
  } run_t;

  localparam run_t RUNS [3] = '{
    '{5'd0,  32'h0000_0001, 2'd0, 1'b0},
    '{5'd17, 32'hDEAD_BEEF, 2'd1, 1'b1},
    '{5'd31, 32'hFFFF_FFFF, 2'd2, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, busReady = 1'b0, syncClk = 1'b1;
  logic [DLY_W-1:0]  syncDelay = '0;
  logic [DATA_W-1:0] tuneWord = '0;
  logic              wrValid, ioUpdate, masterReset, done;
  logic [DEV_W-1:0]  wrDev;
  logic [7:0]        wrAddr;
  logic [DATA_W-1:0] wrData;

  sync_seq_top #(.N_DEV(N_DEV), .MASTER_IDX(MASTER), .DLY_W(DLY_W),
                 .DATA_W(DATA_W), .RST_CYC(RST_CYC)) dut (
    .clk(clk), .rstN(rstN), .start(start), .syncDelay(syncDelay),
    .tuneWord(tuneWord), .busReady(busReady), .syncClk(syncClk),
    .wrValid(wrValid), .wrDev(wrDev), .wrAddr(wrAddr), .wrData(wrData),
    .ioUpdate(ioUpdate), .masterReset(masterReset), .done(done));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, syncCnt = 0, fallCyc = 0;
  logic [1:0] stallMode = 2'd0;

  // expected event stream, owned by the main block
  logic        expUpd   [MAXEV];
  logic        expFinal [MAXEV];
  int          expDev   [MAXEV];
  logic [7:0]  expAddr  [MAXEV];
  logic [31:0] expData  [MAXEV];
  string       expReq   [MAXEV];
  int          expLen = 0;

  // monitor state, owned by the monitor block
  int   evIdx = 0, rstHigh = 0;
  logic prevAccept = 1'b0, prevStall = 1'b0, prevUpd = 1'b0, prevDone = 1'b0;
  logic [DEV_W-1:0] pDev;
  logic [7:0] pAddr;
  logic [31:0] pData;

  task automatic chk(input logic ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic addW(input int d, input logic [7:0] a, input logic [31:0] v, input string r);
    expUpd[expLen] = 1'b0; expFinal[expLen] = 1'b0;
    expDev[expLen] = d; expAddr[expLen] = a; expData[expLen] = v; expReq[expLen] = r;
    expLen++;
  endtask

  task automatic addU(input logic fin, input string r);
    expUpd[expLen] = 1'b1; expFinal[expLen] = fin;
    expDev[expLen] = 0; expAddr[expLen] = 0; expData[expLen] = 0; expReq[expLen] = r;
    expLen++;
  endtask

  task automatic build(input logic [DLY_W-1:0] dly, input logic [31:0] tune);
    for (int d = 0; d < N_DEV; d++) addW(d, 8'h03, 32'h0100_0000, "R4");
    addU(1'b0, "R11");
    for (int d = 0; d < N_DEV; d++) addW(d, 8'h03, 32'h0, "R4");
    addU(1'b0, "R11");
    addW(MASTER, 8'h01, 32'h0000_0200, "R5");
    addU(1'b0, "R5");
    for (int d = 0; d < N_DEV; d++) addW(d, 8'h1B, 32'h0100_0000, "R6");
    addU(1'b0, "R6");
    addW(MASTER, 8'h1B, 32'h0100_0000 | 32'(dly), "R6");
    addU(1'b0, "R6");
    for (int d = 0; d < N_DEV; d++) addW(d, 8'h03, 32'h0100_0000, "R7");
    addU(1'b0, "R7");
    for (int d = 0; d < N_DEV; d++) addW(d, 8'h03, 32'h0, "R7");
    addU(1'b0, "R7");
    for (int d = 0; d < N_DEV; d++) addW(d, 8'h01, 32'h0080_0000, "R8");
    for (int d = 0; d < N_DEV; d++) addW(d, 8'h0B, tune, "R8");
    addU(1'b1, "R9");
  endtask

  // sync clock copy and bus back-pressure, driven just after the edge
  always @(posedge clk) begin
    cyc++;
    #1;
    if (syncCnt == SYNC_HALF - 1) begin
      syncCnt = 0;
      syncClk = ~syncClk;
      if (!syncClk) fallCyc = cyc;
    end else syncCnt++;
    case (stallMode)
      2'd0: busReady = 1'b1;
      2'd1: busReady = cyc[0];
      default: busReady = (cyc % 3 == 0);
    endcase
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (masterReset) rstHigh++;
      // R2: a stalled write holds its fields
      if (prevStall)
        chk(wrValid && wrDev == pDev && wrAddr == pAddr && wrData == pData, "R2",
            $sformatf("held write changed: valid=%0b dev=%0d addr=%h data=%h exp dev=%0d addr=%h data=%h",
                      wrValid, wrDev, wrAddr, wrData, pDev, pAddr, pData));
      if (wrValid && busReady) begin
        if (evIdx < expLen && !expUpd[evIdx])
          chk(int'(wrDev) == expDev[evIdx] && wrAddr == expAddr[evIdx] && wrData == expData[evIdx],
              {expReq[evIdx], "/R3"},
              $sformatf("event %0d write dev=%0d addr=%h data=%h exp dev=%0d addr=%h data=%h",
                        evIdx, wrDev, wrAddr, wrData, expDev[evIdx], expAddr[evIdx], expData[evIdx]));
        else
          chk(1'b0, "R3", $sformatf("event %0d unexpected write addr=%h exp update", evIdx, wrAddr));
        evIdx++;
      end
      if (ioUpdate) begin
        if (evIdx < expLen && expUpd[evIdx]) begin
          if (expFinal[evIdx])
            chk(!syncClk && (cyc - fallCyc == 2), "R9",
                $sformatf("final update syncClk=%0b delay=%0d exp syncClk=0 delay=2",
                          syncClk, cyc - fallCyc));
          else
            chk(prevAccept, expReq[evIdx],
                $sformatf("update %0d prevAccept=%0b exp 1", evIdx, prevAccept));
        end else
          chk(1'b0, "R11", $sformatf("event %0d unexpected update exp write", evIdx));
        evIdx++;
      end
      // R10: done rises the cycle after an update
      if (done && !prevDone)
        chk(prevUpd, "R10", $sformatf("done rose, prior update=%0b exp 1", prevUpd));
      prevAccept = wrValid && busReady;
      prevStall  = wrValid && !busReady;
      prevUpd    = ioUpdate;
      prevDone   = done;
      pDev = wrDev; pAddr = wrAddr; pData = wrData;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!wrValid && !ioUpdate && !masterReset && !done, "R1",
        $sformatf("in reset valid=%0b upd=%0b rst=%0b done=%0b exp 0000",
                  wrValid, ioUpdate, masterReset, done));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!wrValid && !ioUpdate && !masterReset && !done, "R1",
        $sformatf("idle valid=%0b upd=%0b rst=%0b done=%0b exp 0000",
                  wrValid, ioUpdate, masterReset, done));

    for (int r = 0; r < 3; r++) begin
      int rst0, waitCnt;
      build(RUNS[r].dly, RUNS[r].tune);
      stallMode = RUNS[r].stall;
      syncDelay = RUNS[r].dly;
      tuneWord  = RUNS[r].tune;
      rst0 = rstHigh;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      syncDelay = ~RUNS[r].dly;   // captured at start; later changes must not matter
      tuneWord  = ~RUNS[r].tune;
      if (RUNS[r].poke) begin
        // R10: start while busy is ignored
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      waitCnt = 0;
      while (!done && waitCnt < 5000) begin
        @(negedge clk);
        waitCnt++;
      end
      chk(done, "R10", $sformatf("run %0d watchdog done=%0b exp 1", r, done));
      chk(rstHigh - rst0 == RST_CYC, "R1",
          $sformatf("run %0d reset cycles=%0d exp %0d", r, rstHigh - rst0, RST_CYC));
      chk(evIdx == expLen, "R3", $sformatf("run %0d events=%0d exp %0d", r, evIdx, expLen));
      repeat (6) @(negedge clk);
      chk(done && !wrValid && !ioUpdate, "R10",
          $sformatf("run %0d hold done=%0b valid=%0b upd=%0b exp 100", r, done, wrValid, ioUpdate));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // global watchdog
  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: timeout reached, exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule